// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags and Line Status

This block sits between a serial receiver's deserializer and a host register interface. Each character the deserializer delivers is stored in a 64-entry FIFO together with three error tags: break, framing and parity. A break tag means the line stayed low for one whole character time. A framing tag means no valid stop bit was seen. A parity tag means the parity check failed. When a character carries the break tag, the FIFO stores its data byte as 0x00, whatever value arrived with it.

The host has two read strobes. A read of the holding register pops the oldest character and captures it on `rhr_data`. A status read has no effect on the FIFO contents; its only side effect is to clear the overrun flag. The status byte is assembled live. It shows whether any characters are held, the overrun flag, the tags of the character that will be read next, and two transmitter-empty indications that pass through from outside. It also has a summary bit that stays high while any tagged character remains anywhere in the FIFO.

Top module: `rxf_status_fifo`

## Requirements
- R1: After reset the FIFO is empty, `lsr[4:0]` is 0, `lsr[7]` is 0 and `rhr_data` is 0x00.
- R2: `lsr[0]` is 1 exactly when at least one character is held in the FIFO.
- R3: Characters are read out in arrival order, and up to DEPTH (64) can be held. On a holding-register read of a non-empty FIFO, the head character appears on `rhr_data` one clock later.
- R4: `lsr[4:2]` equals {break, framing, parity} of the head entry and follows the head combinationally. It is 0 when the FIFO is empty.
- R5: A character pushed with its break tag set is stored, and later read out, as data 0x00.
- R6: A status read (`lsr_rd`) never changes the FIFO occupancy or the head entry.
- R7: `lsr[7]` is 1 while at least one held entry has any tag set, and 0 once no tagged entries remain. This holds under simultaneous push and pop.
- R8: A character that arrives while the FIFO holds DEPTH entries is dropped, even if a pop happens in the same cycle. The drop leaves the contents unchanged and sets `lsr[1]`. A status read clears `lsr[1]` on the next clock, unless a new drop happens in the same cycle, in which case the drop wins.
- R9: A holding-register read while the FIFO is empty leaves `rhr_data` and the FIFO unchanged.
- R10: `lsr[5]` follows `thr_empty` and `lsr[6]` follows `tx_idle` combinationally.
- R11: A push and a pop in the same cycle on a FIFO that is neither full nor empty leave the occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | Character strobe from the deserializer |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break tag for the character |
| rx_frm | input | 1 | Framing error tag |
| rx_par | input | 1 | Parity error tag |
| rhr_rd | input | 1 | Holding-register read strobe (pops the head) |
| lsr_rd | input | 1 | Status read strobe (clears overrun) |
| thr_empty | input | 1 | Transmit holding register or FIFO empty |
| tx_idle | input | 1 | Transmit holding and shift registers empty |
| rhr_data | output | 8 | Last character popped |
| lsr | output | 8 | Line status byte |

## Verification
A wrong pointer or occupancy count shows up in the very next status sample as a mismatch in `lsr[0]` or `lsr[4:2]`, and in the following holding-register read as a mismatch in `rhr_data`. A drifting tagged-entry count shows up in `lsr[7]` at the first cycle where the real set of tagged entries disagrees with it. That can take until the FIFO drains, so the bench empties the FIFO completely many times. The expected overrun and full-boundary behaviour is modelled from a queue, and it is compared every cycle, including the cycles where a status read and a drop coincide.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxf_entry_t;

  localparam int unsigned TAG_W = 3;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_req,
  input  rxf_entry_t                    push_entry,
  input  logic                          pop_req,
  output rxf_entry_t                    head,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          push_acc,
  output logic                          pop_acc
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  rxf_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] level_q, level_d;

  assign empty    = (level_q == '0);
  assign full     = (level_q == FULL_LVL);
  assign level    = level_q;
  assign push_acc = push_req & ~full;
  assign pop_acc  = pop_req & ~empty;
  assign head     = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push_acc) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_acc) begin
      rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    end
    unique case ({push_acc, pop_acc})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  // storage array: written only on an accepted push, no reset needed
  always_ff @(posedge clk) begin
    if (push_acc) begin
      mem[wr_ptr_q] <= push_entry;
    end
  end

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= FULL_LVL);

  a_r11_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(level_q));

  a_r8_full_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> full);

  a_r3_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0 || level_q == FULL_LVL) |-> (wr_ptr_q == rd_ptr_q));
endmodule

// File: rtl/rxf_tag_count.sv
module rxf_tag_count #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic tagged_any
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] MAX_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tagged_any = (cnt_q != '0);

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |-> (cnt_q != '0));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> (cnt_q != MAX_CNT));
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lsr_rd,
  input  logic             ovr_evt,
  input  logic             empty,
  input  logic [TAG_W-1:0] head_tags,
  input  logic             tagged_any,
  input  logic             thr_empty,
  input  logic             tx_idle,
  output logic [7:0]       lsr
);
  logic ovr_q, ovr_d;
  logic ovr_en;

  // a fresh drop wins over a clearing status read
  assign ovr_en = ovr_evt | lsr_rd;

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_en) begin
      ovr_d = ovr_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  assign lsr = {tagged_any,
                tx_idle,
                thr_empty,
                head_tags & {TAG_W{~empty}},
                ovr_q,
                ~empty};

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !lsr_rd) |=> ovr_q);

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> lsr[1]);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !lsr[1]);
endmodule

// File: rtl/rxf_status_fifo.sv
module rxf_status_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_brk,
  input  logic       rx_frm,
  input  logic       rx_par,
  input  logic       rhr_rd,
  input  logic       lsr_rd,
  input  logic       thr_empty,
  input  logic       tx_idle,
  output logic [7:0] rhr_data,
  output logic [7:0] lsr
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rxf_entry_t      in_entry;
  rxf_entry_t      head;
  logic            empty, full;
  logic [CW-1:0]   level;
  logic            push_acc, pop_acc;
  logic            ovr_evt;
  logic            tag_inc, tag_dec;
  logic            tagged_any;
  logic [7:0]      rhr_q, rhr_d;

  // a break character is stored with a zero data byte
  always_comb begin
    in_entry.brk  = rx_brk;
    in_entry.frm  = rx_frm;
    in_entry.par  = rx_par;
    in_entry.data = rx_brk ? 8'h00 : rx_data;
  end

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (rx_valid),
    .push_entry (in_entry),
    .pop_req    (rhr_rd),
    .head       (head),
    .empty      (empty),
    .full       (full),
    .level      (level),
    .push_acc   (push_acc),
    .pop_acc    (pop_acc)
  );

  assign ovr_evt = rx_valid & full;
  assign tag_inc = push_acc & (rx_brk | rx_frm | rx_par);
  assign tag_dec = pop_acc & (head.brk | head.frm | head.par);

  rxf_tag_count #(.DEPTH(DEPTH)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (tag_inc),
    .dec        (tag_dec),
    .tagged_any (tagged_any)
  );

  rxf_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .lsr_rd     (lsr_rd),
    .ovr_evt    (ovr_evt),
    .empty      (empty),
    .head_tags  ({head.brk, head.frm, head.par}),
    .tagged_any (tagged_any),
    .thr_empty  (thr_empty),
    .tx_idle    (tx_idle),
    .lsr        (lsr)
  );

  always_comb begin
    rhr_d = rhr_q;
    if (pop_acc) begin
      rhr_d = head.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhr_q <= 8'h00;
    end else begin
      rhr_q <= rhr_d;
    end
  end

  assign rhr_data = rhr_q;

  a_r6_status_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rhr_rd && !rx_valid) |=> $stable(level));

  a_r9_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && empty) |=> $stable(rhr_data));

  a_r5_break_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && head.brk) |=> (rhr_data == 8'h00));

  a_r7_summary_covers_head: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[4:2] != 3'b000) |-> lsr[7]);

  a_r2_level_vs_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[0] == (level != '0));
endmodule

// File: tb/tb_rxf_status_fifo.sv
module tb_rxf_status_fifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_brk, rx_frm, rx_par;
  logic [7:0] rx_data;
  logic       rhr_rd, lsr_rd, thr_empty, tx_idle;
  logic [7:0] rhr_data, lsr;

  logic [10:0] q[$];
  bit          m_ovr;
  logic [7:0]  m_rhr;
  int          n_vec;
  int          n_bad;

  always #5 clk = ~clk;

  rxf_status_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par), .rhr_rd(rhr_rd),
    .lsr_rd(lsr_rd), .thr_empty(thr_empty), .tx_idle(tx_idle),
    .rhr_data(rhr_data), .lsr(lsr)
  );

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FIFO check FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit         any;
    logic [2:0] tags;
    any = 1'b0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) any = 1'b1;
    tags = (q.size() != 0) ? q[0][10:8] : 3'b000;
    chk("R2 nonempty bit", lsr[0], (q.size() != 0));
    chk("R8 overrun bit", lsr[1], m_ovr);
    chk("R4/R6 head tags", lsr[4:2], tags);
    chk("R10 tx bits", lsr[6:5], {tx_idle, thr_empty});
    chk("R7 tag summary", lsr[7], any);
    chk("R3/R5/R9 rhr data", rhr_data, m_rhr);
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic cyc(bit v, logic [7:0] d, bit b, bit f, bit p,
                     bit rr, bit lr, bit te, bit ti);
    bit pop_ok, push_ok;
    rx_valid = v; rx_data = d; rx_brk = b; rx_frm = f; rx_par = p;
    rhr_rd = rr; lsr_rd = lr; thr_empty = te; tx_idle = ti;
    @(posedge clk);
    #1;
    pop_ok  = rr && (q.size() != 0);
    push_ok = v && (q.size() < DEPTH);
    if (pop_ok) begin
      m_rhr = q[0][7:0];
      void'(q.pop_front());
    end
    if (v && !push_ok) m_ovr = 1'b1;
    else if (lr)       m_ovr = 1'b0;
    if (push_ok) q.push_back({b, f, p, (b ? 8'h00 : d)});
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("Watchdog FAIL: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0; m_ovr = 1'b0; m_rhr = 8'h00;
    rst_n = 1'b0;
    rx_valid = 1'b1; rx_data = 8'hA5; rx_brk = 1'b1; rx_frm = 1'b1; rx_par = 1'b1;
    rhr_rd = 1'b0; lsr_rd = 1'b0; thr_empty = 1'b1; tx_idle = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 lsr low bits", lsr[4:0], 0);
    chk("R1 lsr summary", lsr[7], 0);
    chk("R1 rhr data", rhr_data, 0);
    chk("R10 tx bits in reset", lsr[6:5], 2'b01);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);

    // R3/R4/R5: fill to capacity, sweeping all tag combinations
    for (int i = 0; i < DEPTH; i++)
      cyc(1, 8'(i * 37 + 11), i[0] & i[3], i[1], i[2], 0, 0, i[4], i[5]);
    // R8: drops when full, alone, with a pop, with a status read
    cyc(1, 8'hEE, 0, 0, 1, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1);
    cyc(1, 8'hDD, 1, 0, 0, 0, 1, 1, 1);
    cyc(1, 8'hCC, 0, 0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R6: status reads only
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 1, 1, 0);
    // R3/R7: drain with interleaved status reads
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 0, 0, 1, i[0], 0, 1);
    // R9: reads of an empty FIFO
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0, 1, 1);
    // R11: simultaneous push/pop at small occupancies with every tag pattern
    for (int lvl = 1; lvl < 4; lvl++) begin
      for (int i = 0; i < lvl; i++) cyc(1, 8'(lvl * 16 + i), 0, i[0], 0, 0, 0, 1, 1);
      for (int t = 0; t < 8; t++) cyc(1, 8'(t * 29 + 3), t[2], t[1], t[0], 1, 0, 1, 1);
      for (int i = 0; i < lvl + 1; i++) cyc(0, 0, 0, 0, 0, 1, 0, 1, 1);
    end
    // R7: push and pop into empty in the same cycle with a tag
    cyc(1, 8'h42, 0, 1, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 1);
    // mixed traffic, biased to reach both full and empty
    for (int k = 0; k < 6000; k++) begin
      int  ph;
      bit  v, rr;
      ph = (k / 400) % 2;
      v  = ($urandom % 100) < (ph ? 70 : 30);
      rr = ($urandom % 100) < (ph ? 30 : 70);
      cyc(v, 8'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0,
          ($urandom % 5) == 0, rr, ($urandom % 4) == 0,
          1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule